// File: doc/BRIEF.md
# Seconds Prescaler with Busy Window and Reference Strobes

This block turns a 32.768 kHz tick enable into the once-per-second count strobe that advances a clock/calendar. The tick is a single-cycle enable in the system clock domain. It feeds a 15-stage binary divider, and the count strobe fires on the tick that wraps the divider from all ones to zero. Around each count strobe the block drives an active-low busy window. Bus logic uses this window to hold off reads and writes while the digit counters change.

The block also drives four reference signals:
- a 1024 Hz square wave;
- narrow active-low strobes once per second, once per minute and once per hour.

The minute and hour strobes come from small rollover counters inside the block. A synchronous clear input zeroes only the upper stages of the divider and the busy logic, and leaves the lower stages running. After the clear is released, the first count strobe arrives about one second later, with an uncertainty of one lower-stage period.

Top module: `rtc_prescaler`

## Requirements
- R1: The divider advances only on cycles with `tick_i` high. With `tick_i` low no state changes, and `cnt_en_o` stays low.
- R2: `cnt_en_o` is high for exactly one cycle per 2^DIV_BITS ticks. It goes high on the cycle whose tick moves the divider from all ones to zero. The first strobe after reset comes on tick number 2^DIV_BITS.
- R3: `busy_n_o` goes low 8 ticks before each count strobe. It is low in the cycle the strobe is high.
- R4: After each count strobe, `busy_n_o` stays low for 6 more ticks. The window is 14 ticks in all. It does not start at reset.
- R5: `ref_fast_o` is a 50 % square wave with a period of 32 ticks. It is high for 16 ticks, in step with divider bit 4.
- R6: `ref_sec_n_o` is low for exactly 4 ticks, starting at each count strobe.
- R7: `ref_min_n_o` is low for 4 ticks starting at every SEC_PER_MIN-th count strobe. The first such strobe is the SEC_PER_MIN-th strobe after reset.
- R8: `ref_hr_n_o` is low for 4 ticks starting at every (SEC_PER_MIN*MIN_PER_HOUR)-th count strobe. It always coincides with a minute pulse.
- R9: While `clr_i` is high:
  - the upper TOP_BITS divider stages are held at zero;
  - `busy_n_o` is high and no count strobe occurs;
  - the three slow references are high.
- R10: `clr_i` leaves the lower DIV_BITS-TOP_BITS stages counting. Say the lower stages hold value L at release. The next count strobe comes after 2^DIV_BITS-1-L ticks, and busy falls 8 ticks before it.
- R11: While `rst_ni` is low, the following hold:
  - `busy_n_o`, `ref_sec_n_o`, `ref_min_n_o` and `ref_hr_n_o` are high;
  - `ref_fast_o` is low;
  - `cnt_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 32.768 kHz single-cycle tick enable |
| clr_i | input | 1 | Clears the upper divider stages and the busy logic |
| cnt_en_o | output | 1 | One-cycle count strobe per second |
| busy_n_o | output | 1 | Active-low busy window around each count strobe |
| ref_fast_o | output | 1 | 1024 Hz square wave, positive logic |
| ref_sec_n_o | output | 1 | Once-per-second 4-tick low strobe |
| ref_min_n_o | output | 1 | Once-per-minute 4-tick low strobe |
| ref_hr_n_o | output | 1 | Once-per-hour 4-tick low strobe |

## Verification
A wrong divider value shows up at once on `ref_fast_o` if the error is in bit 4 or below. An error in a higher bit shows up only as a shifted busy fall or count strobe, up to one second later. The bench therefore checks the strobe and busy edges at exact tick counts, not just their rate. A wrong rollover counter stays hidden until the next minute or hour boundary, so the bench runs a reduced minute and hour to reach those boundaries. An error in the clear path shows up only as the gap between release and the next strobe. That gap is measured in ticks against the value the lower stages held at release.

// File: rtl/rtc_prescaler_pkg.sv
package rtc_prescaler_pkg;
  localparam int unsigned BUSY_LEAD = 8;   // ticks of busy before the count edge
  localparam int unsigned BUSY_TAIL = 6;   // ticks of busy after it
  localparam int unsigned REF_PULSE = 4;   // width of the slow reference strobes
  localparam int unsigned FAST_TAP  = 4;   // divider bit giving 1024 Hz
  localparam int unsigned NUM_REFS  = 3;
endpackage

// File: rtl/rtc_prescaler_div.sv
module rtc_prescaler_div #(
  parameter int unsigned DIV_BITS = 15,
  parameter int unsigned TOP_BITS = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                clr_i,
  output logic [DIV_BITS-1:0] cnt_o,
  output logic                wrap_o
);
  localparam int unsigned LOW_BITS = DIV_BITS - TOP_BITS;

  logic [LOW_BITS-1:0] low_q;
  logic [TOP_BITS-1:0] top_q;

  // lower stages never see the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     low_q <= '0;
    else if (tick_i) low_q <= low_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                top_q <= '0;
    else if (clr_i)             top_q <= '0;
    else if (tick_i && &low_q)  top_q <= top_q + 1'b1;
  end

  assign cnt_o  = {top_q, low_q};
  assign wrap_o = tick_i && !clr_i && (&cnt_o);

  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/rtc_pulse_stretch.sv
module rtc_pulse_stretch #(
  parameter int unsigned WIDTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  input  logic load_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(WIDTH + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (load_i)                 cnt_q <= CW'(WIDTH);
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  a_r6_load_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> active_o);
endmodule

// File: rtl/rtc_rollover_cnt.sv
module rtc_rollover_cnt #(
  parameter int unsigned MOD = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic wrap_o
);
  localparam int unsigned CW = (MOD > 2) ? $clog2(MOD) : 1;

  logic [CW-1:0] cnt_q;

  assign wrap_o = step_i && (cnt_q == CW'(MOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  a_r7_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(MOD - 1));
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_prescaler_pkg::*;
#(
  parameter int unsigned DIV_BITS     = 15,
  parameter int unsigned TOP_BITS     = 5,
  parameter int unsigned SEC_PER_MIN  = 60,
  parameter int unsigned MIN_PER_HOUR = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic cnt_en_o,
  output logic busy_n_o,
  output logic ref_fast_o,
  output logic ref_sec_n_o,
  output logic ref_min_n_o,
  output logic ref_hr_n_o
);
  localparam logic [DIV_BITS-1:0] LEAD_START = {DIV_BITS{1'b1}} - DIV_BITS'(BUSY_LEAD - 1);

  logic [DIV_BITS-1:0] cnt;
  logic                wrap, min_ev, hr_ev;
  logic                pre_win, tail_act;
  logic [NUM_REFS-1:0] ref_load, ref_act;

  rtc_prescaler_div #(.DIV_BITS(DIV_BITS), .TOP_BITS(TOP_BITS)) u_div (
    .clk_i, .rst_ni, .tick_i, .clr_i, .cnt_o(cnt), .wrap_o(wrap)
  );

  rtc_rollover_cnt #(.MOD(SEC_PER_MIN)) u_sec (
    .clk_i, .rst_ni, .step_i(wrap), .wrap_o(min_ev)
  );

  rtc_rollover_cnt #(.MOD(MIN_PER_HOUR)) u_min (
    .clk_i, .rst_ni, .step_i(min_ev), .wrap_o(hr_ev)
  );

  // leading half of busy: top stages are zero under clear, so this stays off
  assign pre_win = (cnt >= LEAD_START);

  rtc_pulse_stretch #(.WIDTH(BUSY_TAIL)) u_tail (
    .clk_i, .rst_ni, .tick_i, .clr_i, .load_i(wrap), .active_o(tail_act)
  );

  assign ref_load = {hr_ev, min_ev, wrap};

  for (genvar i = 0; i < NUM_REFS; i++) begin : g_ref
    rtc_pulse_stretch #(.WIDTH(REF_PULSE)) u_ref (
      .clk_i, .rst_ni, .tick_i, .clr_i, .load_i(ref_load[i]), .active_o(ref_act[i])
    );
  end

  assign cnt_en_o    = wrap;
  assign busy_n_o    = !(pre_win || tail_act);
  assign ref_fast_o  = cnt[FAST_TAP];
  assign ref_sec_n_o = !ref_act[0];
  assign ref_min_n_o = !ref_act[1];
  assign ref_hr_n_o  = !ref_act[2];

  a_r1_no_strobe_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |-> !cnt_en_o);
  a_r2_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_o |=> !cnt_en_o);
  a_r3_busy_at_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_o |-> !busy_n_o);
  a_r4_busy_after_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_o && !clr_i) |=> !busy_n_o);
  a_r6_ref_after_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_o && !clr_i) |=> !ref_sec_n_o);
  a_r7_min_in_sec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_min_n_o |-> !ref_sec_n_o);
  a_r8_hr_in_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_hr_n_o |-> !ref_min_n_o);
  a_r9_clr_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (busy_n_o && !cnt_en_o && ref_sec_n_o && ref_min_n_o && ref_hr_n_o));
endmodule

// File: tb/rtc_prescaler_test.sv
module rtc_prescaler_test;
  // reduced sizes: 4096 ticks per second, 3 s per minute, 2 min per hour
  localparam int unsigned DIV_BITS = 12;
  localparam int unsigned TOP_BITS = 5;
  localparam int NVEC = 17;

  // {tick count, busy_n, sec_n, min_n, hr_n, fast, cnt_en}
  localparam logic [22:0] VEC [NVEC] = '{
    {17'd0,     6'b111100},
    {17'd5,     6'b111100},
    {17'd16,    6'b111110},
    {17'd4087,  6'b111110},
    {17'd4088,  6'b011110},
    {17'd4095,  6'b011111},
    {17'd4096,  6'b001100},
    {17'd4099,  6'b001100},
    {17'd4100,  6'b011100},
    {17'd4101,  6'b011100},
    {17'd4102,  6'b111100},
    {17'd8191,  6'b011111},
    {17'd12288, 6'b000100},
    {17'd12292, 6'b011100},
    {17'd24576, 6'b000000},
    {17'd24579, 6'b000000},
    {17'd24580, 6'b011100}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic clr_i = 1'b0;
  logic cnt_en_o, busy_n_o, ref_fast_o, ref_sec_n_o, ref_min_n_o, ref_hr_n_o;

  int n_chk = 0;
  int n_fail = 0;
  int ticks = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  rtc_prescaler #(.DIV_BITS(DIV_BITS), .TOP_BITS(TOP_BITS),
                  .SEC_PER_MIN(3), .MIN_PER_HOUR(2)) uut (
    .clk_i, .rst_ni, .tick_i, .clr_i, .cnt_en_o, .busy_n_o,
    .ref_fast_o, .ref_sec_n_o, .ref_min_n_o, .ref_hr_n_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at tick %0d: actual %0d expected %0d", tag, ticks, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    if (tick_i) ticks++;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(100000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int eb, ee;
    bit clr_ok;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk("R11 busy_n", busy_n_o, 1);
    chk("R11 sec_n", ref_sec_n_o, 1);
    chk("R11 min_n", ref_min_n_o, 1);
    chk("R11 hr_n", ref_hr_n_o, 1);
    chk("R11 fast", ref_fast_o, 0);
    chk("R11 cnt_en", cnt_en_o, 0);
    rst_ni = 1'b1;
    tick_i = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      while (ticks < int'(VEC[v][22:6])) step();
      chk("R3 R4 busy_n", busy_n_o,    VEC[v][5]);
      chk("R6 sec_n",     ref_sec_n_o, VEC[v][4]);
      chk("R7 min_n",     ref_min_n_o, VEC[v][3]);
      chk("R8 hr_n",      ref_hr_n_o,  VEC[v][2]);
      chk("R5 fast",      ref_fast_o,  VEC[v][1]);
      chk("R2 cnt_en",    cnt_en_o,    VEC[v][0]);
    end

    // R1: gate the tick on the all-ones divider value
    while (ticks < 28671) step();
    chk("R2 cnt_en at all ones", cnt_en_o, 1);
    tick_i = 1'b0;
    #1;
    chk("R1 cnt_en with tick low", cnt_en_o, 0);
    repeat (5) step();
    chk("R1 cnt_en held idle", cnt_en_o, 0);
    chk("R1 busy_n held idle", busy_n_o, 0);
    chk("R1 fast held idle", ref_fast_o, 1);
    tick_i = 1'b1;
    #1;
    chk("R1 cnt_en on resumed tick", cnt_en_o, 1);
    step();

    // R9/R10: clear inside the busy lead, lower stages at 122
    while (ticks < 28672 + 4090) step();
    chk("R3 busy_n before clear", busy_n_o, 0);
    clr_i = 1'b1;
    clr_ok = 1'b1;
    for (int h = 0; h < 134; h++) begin
      step();
      if (!busy_n_o || cnt_en_o || !ref_sec_n_o) clr_ok = 1'b0;
    end
    chk("R9 quiet while clear held", clr_ok, 1);
    clr_i = 1'b0;
    // lower stages are now 0: strobe after 4095 ticks, busy after 4088
    eb = -1;
    ee = -1;
    for (int n = 0; n <= 4200 && ee < 0; n++) begin
      if (eb < 0 && !busy_n_o) eb = n;
      if (cnt_en_o) ee = n;
      if (ee < 0) step();
    end
    chk("R10 ticks to first strobe", ee, 4095);
    chk("R10 ticks to busy fall", eb, 4088);

    done = 1'b1;
    finish_run();
  end
endmodule